// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Prescale Mode

This block is one timer/counter channel. It holds a count in two bytes, a high byte and a low byte. In timer mode the count advances once per machine cycle, and a machine cycle is a fixed group of 12 oscillator clocks. In counter mode the count advances on falling edges of an external pin. The pin is sampled once per machine cycle, so a falling edge is seen only when one sample is high and the next sample is low.

A 2-bit mode input selects how the two bytes are joined:
- In the 13-bit mode, the high byte counts behind a divide-by-32 prescaler. The prescaler is the low five bits of the low byte.
- In the 16-bit mode, both bytes form one up-counter.

Software can load either byte at any time. A sticky overflow flag marks each rollover of the active count. Software clears the flag with a clear strobe, or an interrupt-acknowledge pulse clears it.

Top module: `cycle_timer`

## Requirements
- R1: After reset, `hiByte`, `loByte` and `ovfFlag` are all zero.
- R2: An internal machine-cycle counter starts at reset and completes every 12 clocks; the first completion is on the 12th rising edge after reset is released. With `runEn`=1 and `countSel`=0, the count advances by one on each completion and on no other clock.
- R3: With `countSel`=1 the count advances by one on a machine-cycle completion only when `extPin` was sampled 1 at the previous completion and is 0 at this one; the pin is sampled only at completions, so a level shorter than a machine cycle can be missed.
- R4: With `modeSel`=2'b00, `loByte[4:0]` is a 5-bit prescaler. `hiByte` advances when that prescaler wraps from 31 to 0. Counting never alters `loByte[7:5]`.
- R5: With `modeSel`=2'b01, `{hiByte,loByte}` is a single 16-bit up-counter.
- R6: With `runEn`=0 the count holds its value. Raising `runEn` again resumes from the held value and does not clear it.
- R7: `ovfFlag` sets on the count event that rolls the active count from all ones to zero (mode 00: `hiByte`=0xFF with prescaler 31; mode 01: 0xFFFF). It stays set until `flagClr` or `intAck` is high on a clock. A set and a clear in the same clock leave it set.
- R8: `wrHi`/`wrLo` load `wrData` into the high/low byte on the next rising edge. Any write suppresses the count event of that clock, so no increment and no overflow occur on it.
- R9: With `modeSel` equal to 2'b10 or 2'b11 the count neither advances nor raises `ovfFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable |
| countSel | input | 1 | 0 = timer (machine cycles), 1 = counter (pin falling edges) |
| modeSel | input | 2 | 00 = 13-bit prescale mode, 01 = 16-bit mode, others = halted |
| extPin | input | 1 | External count input |
| wrHi | input | 1 | Load high byte from wrData |
| wrLo | input | 1 | Load low byte from wrData |
| wrData | input | 8 | Byte write data |
| flagClr | input | 1 | Software clear of the overflow flag |
| intAck | input | 1 | Interrupt acknowledge, clears the overflow flag |
| hiByte | output | 8 | High byte of the count |
| loByte | output | 8 | Low byte of the count |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Directed runs cover four patterns, each targeting a different fault:
- A long timer run from reset shows whether increments fall exactly every 12 clocks.
- A prescale run through 40 machine cycles shows whether the high byte moves only on a 5-bit wrap.
- Preloaded values near all ones separate the two rollover widths. They also show the flag surviving a clear that lands on the same clock as a wrap.
- Slow and fast pin waveforms distinguish true sampled-edge detection from raw edge counting.

Random runs then mix modes, run gating, byte writes on count clocks and flag clears. They catch faults in write priority and in the two halted mode codes.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // strobes passed from the control unit to the datapath
  typedef struct packed {
    logic step;    // one count event this clock
    logic loadHi;  // load high byte
    logic loadLo;  // load low byte
    logic wide;    // 16-bit joining selected
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int MC_LEN = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       countSel,
  input  logic [1:0] modeSel,
  input  logic       extPin,
  input  logic       wrHi,
  input  logic       wrLo,
  output tmrStrobe_t strobe
);
  localparam int PH_W = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_LEN - 1);

  logic [PH_W-1:0] phase;
  logic mcTick;
  logic pinSample;
  logic pinFall;
  logic modeOk;
  logic countEvt;

  assign mcTick = (phase == PH_LAST);

  // machine-cycle phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       phase <= '0;
    else if (mcTick) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  // pin sampled once per machine cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pinSample <= 1'b0;
    else if (mcTick) pinSample <= extPin;
  end

  assign pinFall  = mcTick & pinSample & ~extPin;
  assign modeOk   = (modeSel == 2'b00) | (modeSel == 2'b01);
  assign countEvt = countSel ? pinFall : mcTick;

  always_comb begin
    strobe.step   = runEn & countEvt & modeOk & ~wrHi & ~wrLo;
    strobe.loadHi = wrHi;
    strobe.loadLo = wrLo;
    strobe.wide   = (modeSel == 2'b01);
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    mcTick |=> !mcTick);

  // R3
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mcTick |=> $stable(pinSample));

  // R2
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (phase == PH_LAST));
endmodule

// File: rtl/tmr_dp.sv
`timescale 1ns/1ps
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  input  logic              intAck,
  output logic [BYTE_W-1:0] hiByte,
  output logic [BYTE_W-1:0] loByte,
  output logic              ovfFlag
);
  localparam int FULL_W = 2 * BYTE_W;
  localparam logic [PRESC_W-1:0] PRESC_MAX = '1;

  logic [BYTE_W-1:0] hiReg, loReg, nextHi, nextLo;
  logic wrapCond, wrapEvt, flagReg;

  // next count value and rollover condition for the selected joining
  always_comb begin
    nextHi   = hiReg;
    nextLo   = loReg;
    wrapCond = 1'b0;
    if (strobe.wide) begin
      {nextHi, nextLo} = {hiReg, loReg} + FULL_W'(1);
      wrapCond = &{hiReg, loReg};
    end else if (loReg[PRESC_W-1:0] == PRESC_MAX) begin
      nextLo[PRESC_W-1:0] = '0;
      nextHi   = hiReg + 1'b1;
      wrapCond = &hiReg;
    end else begin
      nextLo[PRESC_W-1:0] = loReg[PRESC_W-1:0] + 1'b1;
    end
  end

  assign wrapEvt = strobe.step & wrapCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobe.loadHi || strobe.loadLo) begin
      if (strobe.loadHi) hiReg <= wrData;
      if (strobe.loadLo) loReg <= wrData;
    end else if (strobe.step) begin
      hiReg <= nextHi;
      loReg <= nextLo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagReg <= 1'b0;
    else if (wrapEvt)           flagReg <= 1'b1;
    else if (flagClr || intAck) flagReg <= 1'b0;
  end

  assign hiByte  = hiReg;
  assign loByte  = loReg;
  assign ovfFlag = flagReg;

  // R8
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHi |=> hiByte == $past(wrData));

  // R5
  wide_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.wide && !strobe.loadHi && !strobe.loadLo)
      |=> {hiByte, loByte} == FULL_W'($past({hiByte, loByte}) + FULL_W'(1)));

  // R4
  presc_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.wide && !strobe.loadLo)
      |=> $stable(loByte[BYTE_W-1:PRESC_W]));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> ovfFlag);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr && !intAck) |=> ovfFlag);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.loadHi && !strobe.loadLo)
      |=> $stable(hiByte) && $stable(loByte));
endmodule

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
module cycle_timer
  import tmr_pkg::*;
#(
  parameter int MC_LEN  = 12,
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              countSel,
  input  logic [1:0]        modeSel,
  input  logic              extPin,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  input  logic              intAck,
  output logic [BYTE_W-1:0] hiByte,
  output logic [BYTE_W-1:0] loByte,
  output logic              ovfFlag
);
  tmrStrobe_t strobe;

  tmr_ctrl #(.MC_LEN(MC_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countSel(countSel),
    .modeSel(modeSel), .extPin(extPin), .wrHi(wrHi), .wrLo(wrLo),
    .strobe(strobe)
  );

  tmr_dp #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .flagClr(flagClr), .intAck(intAck),
    .hiByte(hiByte), .loByte(loByte), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/sim_cycle_timer.sv
`timescale 1ns/1ps
module sim_cycle_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, countSel = 0, extPin = 0, wrHi = 0, wrLo = 0, flagClr = 0, intAck = 0;
  logic [1:0] modeSel = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] hiByte, loByte;
  logic ovfFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference model state
  int mPhase = 0;
  bit mSample = 0;
  logic [7:0] mHi = 0, mLo = 0;
  bit mFlag = 0;

  always #2 clk = ~clk;

  cycle_timer u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countSel(countSel),
    .modeSel(modeSel), .extPin(extPin), .wrHi(wrHi), .wrLo(wrLo),
    .wrData(wrData), .flagClr(flagClr), .intAck(intAck),
    .hiByte(hiByte), .loByte(loByte), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(curTag, "hiByte", int'(hiByte), int'(mHi));
    chk(curTag, "loByte", int'(loByte), int'(mLo));
    chk(curTag, "ovfFlag", int'(ovfFlag), int'(mFlag));
  endtask

  // one clock: drive at negedge, predict, advance, compare at next negedge
  task automatic cycle(input bit dRun, input bit dSel, input logic [1:0] dMode, input bit dExt,
                       input bit dWrHi, input bit dWrLo, input logic [7:0] dData,
                       input bit dClr, input bit dAck);
    bit tick, fall, step, wrap;
    logic [7:0] nHi, nLo;
    runEn = dRun; countSel = dSel; modeSel = dMode; extPin = dExt;
    wrHi = dWrHi; wrLo = dWrLo; wrData = dData; flagClr = dClr; intAck = dAck;
    tick = (mPhase == 11);
    fall = tick && mSample && !dExt;
    step = dRun && (dSel ? fall : tick) && (dMode < 2) && !dWrHi && !dWrLo;
    nHi = mHi; nLo = mLo; wrap = 0;
    if (dWrHi) nHi = dData;
    if (dWrLo) nLo = dData;
    if (step) begin
      if (dMode == 2'b01) begin
        wrap = ({mHi, mLo} == 16'hffff);
        {nHi, nLo} = {mHi, mLo} + 16'd1;
      end else if (mLo[4:0] == 5'h1f) begin
        nLo[4:0] = 5'h00;
        nHi = mHi + 8'd1;
        wrap = (mHi == 8'hff);
      end else begin
        nLo[4:0] = mLo[4:0] + 5'd1;
      end
    end
    @(posedge clk);
    mPhase = tick ? 0 : mPhase + 1;
    if (tick) mSample = dExt;
    mHi = nHi; mLo = nLo;
    if (wrap) mFlag = 1;
    else if (dClr || dAck) mFlag = 0;
    @(negedge clk);
    compareAll();
  endtask

  task automatic runFor(input int n, input bit dRun, input bit dSel,
                        input logic [1:0] dMode, input bit dExt);
    for (int i = 0; i < n; i++) cycle(dRun, dSel, dMode, dExt, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic loadBoth(input logic [7:0] h, input logic [7:0] l, input logic [1:0] dMode);
    cycle(0, 0, dMode, extPin, 1, 0, h, 0, 0);
    cycle(0, 0, dMode, extPin, 0, 1, l, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    // R1: reset state
    curTag = "R1";
    compareAll();
    rstN = 1'b1;

    // R2 + R4: 40 machine cycles in prescale timer mode -> hi=1, lo=8
    curTag = "R2";
    runFor(480, 1, 0, 2'b00, 0);
    chk("R4", "hi after 40 mc", int'(hiByte), 1);
    chk("R4", "lo after 40 mc", int'(loByte), 8);

    // R4: upper low-byte bits untouched; wrap of prescaler and high byte
    curTag = "R4";
    loadBoth(8'hff, 8'hfc, 2'b00);
    runFor(12 * 6, 1, 0, 2'b00, 0);
    chk("R4", "upper lo bits kept", int'(loByte[7:5]), 7);
    chk("R7", "flag from mode0 wrap", int'(ovfFlag), 1);

    // R7: software clear, then acknowledge clear
    curTag = "R7";
    cycle(0, 0, 2'b00, 0, 0, 0, 8'h00, 1, 0);
    chk("R7", "flag after clr", int'(ovfFlag), 0);

    // R5: 16-bit rollover
    curTag = "R5";
    loadBoth(8'hff, 8'hfd, 2'b01);
    runFor(12 * 5, 1, 0, 2'b01, 0);
    chk("R7", "flag from 16-bit wrap", int'(ovfFlag), 1);
    cycle(0, 0, 2'b01, 0, 0, 0, 8'h00, 0, 1);
    chk("R7", "flag after ack", int'(ovfFlag), 0);

    // R7: clear held high through a wrap -> set wins on that clock
    curTag = "R7";
    loadBoth(8'hff, 8'hff, 2'b01);
    for (int i = 0; i < 14; i++) begin
      cycle(1, 0, 2'b01, 0, 0, 0, 8'h00, 1, 0);
      if (mFlag) chk("R7", "set wins over clr", int'(ovfFlag), 1);
    end

    // R6: hold with run low, then resume without clearing
    curTag = "R6";
    loadBoth(8'h12, 8'h34, 2'b01);
    runFor(60, 0, 0, 2'b01, 0);
    chk("R6", "held hi", int'(hiByte), 8'h12);
    chk("R6", "held lo", int'(loByte), 8'h34);
    runFor(30, 1, 0, 2'b01, 0);

    // R3: slow pin waveform (12 high, 12 low), then fast toggle every 3 clocks
    curTag = "R3";
    loadBoth(8'h00, 8'h00, 2'b01);
    for (int k = 0; k < 20; k++) begin
      runFor(12, 1, 1, 2'b01, 1);
      runFor(12, 1, 1, 2'b01, 0);
    end
    for (int k = 0; k < 40; k++) runFor(3, 1, 1, 2'b01, k[0]);
    runFor(17, 1, 1, 2'b01, 1);
    runFor(29, 1, 1, 2'b01, 0);

    // R9: halted mode codes
    curTag = "R9";
    loadBoth(8'hff, 8'hff, 2'b10);
    runFor(40, 1, 0, 2'b10, 0);
    runFor(40, 1, 0, 2'b11, 0);
    chk("R9", "no wrap in halted mode", int'(ovfFlag), 0);

    // R8: writes on every clock of a machine cycle suppress counting
    curTag = "R8";
    for (int i = 0; i < 24; i++) cycle(1, 0, 2'b01, 0, 0, 1, 8'h50, 0, 0);
    chk("R8", "lo held by writes", int'(loByte), 8'h50);

    // random mix
    begin
      logic [1:0] rMode;
      bit rRun, rSel, rExt;
      int hold;
      rMode = 0; rRun = 1; rSel = 0; rExt = 0; hold = 0;
      for (int i = 0; i < 6000; i++) begin
        bit rWh, rWl, rClr, rAck;
        if (hold == 0) begin
          rMode = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
          rRun  = ($urandom % 5) != 0;
          rSel  = $urandom % 2;
          hold  = 20 + ($urandom % 200);
        end
        hold--;
        if ($urandom % 9 == 0) rExt = ~rExt;
        rWh  = ($urandom % 60) == 0;
        rWl  = ($urandom % 60) == 0;
        rClr = ($urandom % 40) == 0;
        rAck = ($urandom % 40) == 0;
        curTag = (rWh || rWl) ? "R8" : (rMode == 0) ? "R4" : (rMode == 1) ? "R5" : "R9";
        cycle(rRun, rSel, rMode, rExt, rWh, rWl, 8'($urandom % 4 == 0 ? 8'hff : $urandom), rClr, rAck);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule